// File: doc/BRIEF.md
# Serial Output Freeze Controller

This block sits between a bank of free-running clock sources and the pins they drive. It lets a host stop or restart each output clock individually. The host writes a framed serial word on a data/clock pair. The receiver waits on an idle-high data line for a low start bit. It then samples the following word, least significant bit first, one bit per rising edge of the serial clock. Once the last bit arrives, the whole word is copied into the active enable register in one step.

Each enable bit crosses into the clock domain of the output it controls through two flops. A holding flop that updates on the falling edge of that output's own source then takes up the value. The output is the source ANDed with the held bit. A stopped output therefore rests at 0. Stopping and restarting only ever happen between complete pulses.

Two outputs have no enable bit and always follow their sources: output 0 of bank C and the feedback output. After reset every gated output runs.

Top module: `clk_freeze_ctl`

## Requirements
- R1: While no frame is in progress, a 1 on `ser_dat` is ignored, and the outputs keep their current run/stop state for any length of idle time.
- R2: A 0 sampled while idle starts a frame. The next 3*BANK_W rising edges of `ser_clk` sample data bits D0 (first) to D(3*BANK_W-1). The new word replaces all enables together, at the edge that samples the last bit.
- R3: Bit mapping with BANK_W=4: D0..D3 drive `qa[0..3]`, D4..D7 drive `qb[0..3]`, D8..D10 drive `qc[1..3]`, and D11 drives `sync_out`.
- R4: An enable bit of 1 lets the output follow its source. A bit of 0 stops the output, and it stays at logic 0.
- R5: `qc[0]` and `fb_out` have no enable bit and always equal `qc_src[0]` and `fb_src`.
- R6: A gated output never produces a partial pulse. It rises only together with a rising edge of its source, and every high phase lasts a full source high phase.
- R7: After reset all enable bits are 1, so all outputs run.
- R8: A new start bit may be sampled on the edge right after the last data bit of the previous frame. Back-to-back frames then both take effect.
- R9: After a frame completes, each output reaches its new state within four periods of its own source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_dat | input | 1 | Serial data, idle high |
| qa_src | input | BANK_W | Bank A source clocks |
| qb_src | input | BANK_W | Bank B source clocks |
| qc_src | input | BANK_W | Bank C source clocks (bit 0 ungated) |
| sync_src | input | 1 | Sync source clock |
| fb_src | input | 1 | Feedback source clock (ungated) |
| qa | output | BANK_W | Gated bank A clocks |
| qb | output | BANK_W | Gated bank B clocks |
| qc | output | BANK_W | Bank C clocks, bits 1 and up gated |
| sync_out | output | 1 | Gated sync clock |
| fb_out | output | 1 | Feedback clock, always running |

## Verification
The bench builds the block with its default BANK_W of 4, which gives the full 12-bit frame and makes the bit mapping of every bank observable at the pins. Each of the 12 gated sources runs at its own period with its own phase offset. Enables therefore land at unrelated points of each source cycle, which exercises the runt-free hand-off between domains for many alignments. Pulse widths are measured on every gated output against the source half period.

// File: rtl/clk_freeze_ctl.sv
`timescale 1ns/1ps
module clk_freeze_ctl #(
  parameter int BANK_W = 4
) (
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic [BANK_W-1:0] qa_src,
  input  logic [BANK_W-1:0] qb_src,
  input  logic [BANK_W-1:0] qc_src,
  input  logic              sync_src,
  input  logic              fb_src,
  output logic [BANK_W-1:0] qa,
  output logic [BANK_W-1:0] qb,
  output logic [BANK_W-1:0] qc,
  output logic              sync_out,
  output logic              fb_out
);
  localparam int NG = 3 * BANK_W;
  localparam int CW = $clog2(NG);
  localparam logic [CW-1:0] LAST = CW'(NG - 1);

  logic          busy;
  logic [CW-1:0] bit_idx;
  logic [NG-1:0] shreg;
  logic [NG-1:0] en_reg;
  logic [NG-1:0] src_vec;
  logic [NG-1:0] gated;
  logic [NG-1:0] sync1, sync2, hold;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      en_reg  <= '1;
    end else if (!busy) begin
      if (!ser_dat) begin
        busy    <= 1'b1;
        bit_idx <= '0;
      end
    end else begin
      shreg[bit_idx] <= ser_dat;
      if (bit_idx == LAST) begin
        busy   <= 1'b0;
        en_reg <= {ser_dat, shreg[NG-2:0]};
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign src_vec = {sync_src, qc_src[BANK_W-1:1], qb_src, qa_src};

  for (genvar g = 0; g < NG; g++) begin : g_gate
    always_ff @(posedge src_vec[g] or negedge rst_n) begin
      if (!rst_n) begin
        sync1[g] <= 1'b1;
        sync2[g] <= 1'b1;
      end else begin
        sync1[g] <= en_reg[g];
        sync2[g] <= sync1[g];
      end
    end

    always_ff @(negedge src_vec[g] or negedge rst_n) begin
      if (!rst_n) hold[g] <= 1'b1;
      else        hold[g] <= sync2[g];
    end

    assign gated[g] = src_vec[g] & hold[g];
  end

  assign qa       = gated[BANK_W-1:0];
  assign qb       = gated[2*BANK_W-1:BANK_W];
  assign qc       = {gated[NG-2:2*BANK_W], qc_src[0]};
  assign sync_out = gated[NG-1];
  assign fb_out   = fb_src;
endmodule

// File: rtl/clk_freeze_chk.sv
`timescale 1ns/1ps
module clk_freeze_chk #(
  parameter int BANK_W = 4
) (
  input logic                    rst_n,
  input logic                    ser_clk,
  input logic                    ser_dat,
  input logic                    busy,
  input logic [$clog2(3*BANK_W)-1:0] bit_idx,
  input logic [3*BANK_W-1:0]     en_reg,
  input logic [3*BANK_W-1:0]     src_vec,
  input logic [3*BANK_W-1:0]     gated
);
  localparam int NG = 3 * BANK_W;
  localparam int CW = $clog2(NG);

  AST_START_DETECT: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && !ser_dat) |=> (busy && bit_idx == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && ser_dat) |=> (!busy && $stable(en_reg))); // R1

  AST_FRAME_END: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && bit_idx == CW'(NG - 1)) |=> !busy); // R2

  AST_WORD_ATOMIC: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !(busy && bit_idx == CW'(NG - 1)) |=> $stable(en_reg)); // R2

  AST_RESET_ALL_ON: assert property (@(posedge ser_clk)
    $rose(rst_n) |-> (&en_reg)); // R7

  for (genvar g = 0; g < NG; g++) begin : g_chk
    AST_RISE_ON_EDGE: assert property (@(posedge gated[g]) disable iff (!rst_n)
      !src_vec[g]); // R6
  end
endmodule

bind clk_freeze_ctl clk_freeze_chk #(.BANK_W(BANK_W)) u_chk (
  .rst_n   (rst_n),
  .ser_clk (ser_clk),
  .ser_dat (ser_dat),
  .busy    (busy),
  .bit_idx (bit_idx),
  .en_reg  (en_reg),
  .src_vec (src_vec),
  .gated   (gated)
);

// File: tb/clk_freeze_ctl_tb.sv
`timescale 1ns/1ps
module clk_freeze_ctl_tb;
  localparam int BANK_W = 4;
  localparam int NG = 3 * BANK_W;

  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b1;
  logic [NG-1:0] src;
  logic c0_src = 1'b0;
  logic fb_src = 1'b0;
  logic [BANK_W-1:0] qa, qb, qc;
  logic sync_out, fb_out;
  logic [NG-1:0] gq;

  int checks = 0;
  int failures = 0;
  int runts = 0;
  int rcnt [NG];
  int c0_rises = 0;
  int fb_rises = 0;
  int follow_err = 0;

  always #2.5 ser_clk = ~ser_clk;
  always #4.0 c0_src = ~c0_src;
  always #6.3 fb_src = ~fb_src;

  function automatic real half_of(int g);
    return 3.1 + 0.9 * g;
  endfunction

  for (genvar g = 0; g < NG; g++) begin : g_src
    real t_rise;
    initial begin
      src[g] = 1'b0;
      t_rise = -1.0;
      #(0.2 + 0.37 * g);
      forever #(half_of(g)) src[g] = ~src[g];
    end
    always @(posedge gq[g]) begin
      t_rise = $realtime;
      rcnt[g] = rcnt[g] + 1;
    end
    always @(negedge gq[g]) begin
      if (rst_n && t_rise >= 0.0) begin
        real w;
        w = $realtime - t_rise;
        if (w < half_of(g) - 0.01 || w > half_of(g) + 0.01) runts = runts + 1;
      end
    end
  end

  always @(posedge qc[0]) c0_rises = c0_rises + 1;
  always @(posedge fb_out) fb_rises = fb_rises + 1;
  always @(c0_src or fb_src or qc[0] or fb_out) begin
    #0.001;
    if (qc[0] !== c0_src || fb_out !== fb_src) follow_err = follow_err + 1;
  end

  assign gq = {sync_out, qc[BANK_W-1:1], qb, qa};

  clk_freeze_ctl #(.BANK_W(BANK_W)) u_dut (
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .qa_src   (src[BANK_W-1:0]),
    .qb_src   (src[2*BANK_W-1:BANK_W]),
    .qc_src   ({src[NG-2:2*BANK_W], c0_src}),
    .sync_src (src[NG-1]),
    .fb_src   (fb_src),
    .qa       (qa),
    .qb       (qb),
    .qc       (qc),
    .sync_out (sync_out),
    .fb_out   (fb_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [NG-1:0] w, input bit trail_idle);
    @(negedge ser_clk) ser_dat = 1'b0;
    for (int i = 0; i < NG; i++) @(negedge ser_clk) ser_dat = w[i];
    if (trail_idle) @(negedge ser_clk) ser_dat = 1'b1;
  endtask

  task automatic expect_word(input logic [NG-1:0] w, input string req);
    #120;
    for (int i = 0; i < NG; i++) rcnt[i] = 0;
    #300;
    for (int i = 0; i < NG; i++) begin
      if (w[i]) chk(rcnt[i] > 0, req, rcnt[i], 1);
      else      chk(rcnt[i] == 0 && gq[i] == 1'b0, req, rcnt[i] + int'(gq[i]), 0);
    end
  endtask

  task automatic t_reset;
    expect_word('1, "R7 reset all running");
  endtask

  task automatic t_freeze_all;
    c0_rises = 0;
    fb_rises = 0;
    send_frame('0, 1'b1);
    expect_word('0, "R4 freeze all held low");
    chk(c0_rises > 0, "R5 qc0 runs while frozen", c0_rises, 1);
    chk(fb_rises > 0, "R5 fb runs while frozen", fb_rises, 1);
  endtask

  task automatic t_mapping;
    send_frame(12'hA5C, 1'b1);
    expect_word(12'hA5C, "R3 pattern A5C mapping");
    send_frame(12'h001, 1'b1);
    expect_word(12'h001, "R2 only D0 set (first bit)");
    send_frame(12'h800, 1'b1);
    expect_word(12'h800, "R3 only D11 sync set");
  endtask

  task automatic t_idle;
    send_frame(12'h3C6, 1'b1);
    #1000;
    expect_word(12'h3C6, "R1 idle ones ignored");
  endtask

  task automatic t_back_to_back;
    send_frame(12'h0F0, 1'b0);
    send_frame(12'h70F, 1'b1);
    expect_word(12'h70F, "R8 back-to-back second frame");
  endtask

  task automatic t_latency;
    send_frame(12'hFFF, 1'b1);
    #(8.0 * half_of(NG - 1));
    for (int i = 0; i < NG; i++) rcnt[i] = 0;
    #60;
    for (int i = 0; i < NG; i++) chk(rcnt[i] > 0, "R9 restart within 4 periods", rcnt[i], 1);
  endtask

  task automatic t_runts;
    chk(runts == 0, "R6 no partial pulses", runts, 0);
    chk(follow_err == 0, "R5 ungated outputs follow sources", follow_err, 0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NG; i++) rcnt[i] = 0;
    #23 rst_n = 1'b1;
    t_reset();
    t_freeze_all();
    t_mapping();
    t_idle();
    t_back_to_back();
    t_latency();
    t_runts();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule